// File: doc/BRIEF.md
# Symmetric Up-Down PWM Event Generator

This block is the time base and compare stage of a centre-aligned PWM channel. A counter climbs from zero to a programmable period, then falls back to zero, so one full PWM cycle spans twice the period in clocks. A compare value is written into a shadow register and moves into the active compare register only when the counter sits at zero. This keeps duty changes glitch-free across a cycle.

Every equality between the counter and the active compare value is tagged with a count direction. Two separate consumers read that tag. The output action path applies a configurable set, clear or toggle to the single PWM pin, with one action for up-count matches and one for down-count matches. The interrupt path raises a one-clock pulse and a sticky flag for the chosen direction only. When the compare value equals zero or the period, each cycle has one match instead of two. The two paths classify the match at the period differently: the action path calls it an up-count match, while the interrupt path calls it a down-count match. Firmware running 0 % or 100 % duty relies on this rule.

Top module: `pwm_updown_gen`

## Requirements
- R1: After reset the counter output is 0 with direction up (`dirDown`=0). While enabled, it steps by one per clock from 0 up to the active period P, then down to 0, and repeats, which gives a 2P-clock cycle. `dirDown` is 1 when the counter holds P and on every value of the descent, and 0 at zero and on the ascent.
- R2: The period input is taken only while the counter is at zero and governs the following ascent and descent. A period of 0 holds the counter at zero.
- R3: A shadow write (`cmpWrEn`) never changes the active compare value directly. The shadow is copied to the active value on each clock edge at which the counter is at zero, and the copy is used from the next counter value onward. A write at that same edge is taken at the next zero.
- R4: When the active compare value C satisfies 0 < C < P, the block produces exactly one up-count match and one down-count match per 2P-clock cycle.
- R5: When C = 0, there is one match per cycle, at counter zero, and both paths treat it as an up-count match. The down-direction interrupt selection never fires, and the down action is never applied.
- R6: When C = P, there is one match per cycle. The action path applies the up-count action there. The interrupt path fires only for the down-direction selection.
- R7: Action codes on `actUp`/`actDown`: 0 none, 1 drive high, 2 drive low, 3 toggle. A match shown on `cntOut` in one cycle changes `pwmOut` in the next cycle. `pwmOut` resets to 0.
- R8: `irqDownSel`=0 selects up-count matches and 1 selects down-count matches as the interrupt source. `irqPulse` is high for exactly the one cycle after the selected match is shown on `cntOut`.
- R9: `irqFlag` is set with every `irqPulse` and stays set until `irqClr` is high at a clock edge with no new event. If a clear and an event arrive at the same edge, the flag stays set.
- R10: While `en` is low, the counter is forced to 0 with direction up, no match is produced, and `pwmOut` holds its value.
- R11: A compare value greater than the active period never produces a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low forces the counter to zero |
| periodIn | input | CNT_W | Period value, sampled at counter zero |
| cmpWrEn | input | 1 | Shadow compare write strobe |
| cmpWrData | input | CNT_W | Shadow compare write data |
| irqDownSel | input | 1 | Interrupt source: 0 up-count match, 1 down-count match |
| actUp | input | 2 | Action on an up-count match |
| actDown | input | 2 | Action on a down-count match |
| irqClr | input | 1 | Clears the sticky interrupt flag |
| pwmOut | output | 1 | PWM level |
| cntOut | output | CNT_W | Current counter value |
| dirDown | output | 1 | Count direction, 1 while descending |
| irqPulse | output | 1 | One-clock interrupt event |
| irqFlag | output | 1 | Sticky interrupt flag |

## Verification
The hardest cases to reach are the edge compare values, C = 0 and C = P. They only take effect once a zero crossing has copied the shadow. Each cycle then has a single match, and the two paths must classify it differently. The directed part of the bench writes each edge value and runs long enough to pass a zero. It then counts pulses and output toggles over exactly one full cycle, for both interrupt selections, with action settings that show which direction each path assigned. A random phase with a fixed seed mixes period changes, shadow writes in mid-cycle, enable drops and flag clears, and compares against a cycle model on every clock.

// File: rtl/pwm_updown_pkg.sv
package pwm_updown_pkg;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_SET    = 2'd1,
    ACT_CLEAR  = 2'd2,
    ACT_TOGGLE = 2'd3
  } actE;

  // control -> datapath strobes
  typedef struct packed {
    logic zeroCnt;
    logic stepUp;
    logic stepDown;
    logic turnDown;
    logic turnUp;
    logic loadActive;
  } strobeT;

  // datapath -> control status
  typedef struct packed {
    logic cntIsZero;
    logic cntIsPeriod;
    logic cmpEq;
    logic upHitsPeriod;
    logic downHitsZero;
    logic periodIsZero;
    logic dirDown;
  } statT;

  function automatic logic applyAct(input logic cur, input logic [1:0] code);
    case (actE'(code))
      ACT_SET:    applyAct = 1'b1;
      ACT_CLEAR:  applyAct = 1'b0;
      ACT_TOGGLE: applyAct = ~cur;
      default:    applyAct = cur;
    endcase
  endfunction

endpackage

// File: rtl/pwm_updown_dp.sv
module pwm_updown_dp
  import pwm_updown_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] periodIn,
  input  logic             cmpWrEn,
  input  logic [CNT_W-1:0] cmpWrData,
  input  strobeT           strobe,
  output statT             stat,
  output logic [CNT_W-1:0] cntOut,
  output logic             dirDown
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] perQ;
  logic [CNT_W-1:0] cmpQ;
  logic [CNT_W-1:0] shadowQ;
  logic             dirQ;
  logic [CNT_W-1:0] effPer;
  logic [CNT_W-1:0] cntInc;

  // at zero the live period governs the next ascent
  assign effPer = (cntQ == '0) ? periodIn : perQ;
  assign cntInc = cntQ + ONE;

  always_comb begin
    stat.cntIsZero    = (cntQ == '0);
    stat.cntIsPeriod  = (cntQ == perQ);
    stat.cmpEq        = (cntQ == cmpQ);
    stat.upHitsPeriod = (cntInc == effPer);
    stat.downHitsZero = (cntQ == ONE);
    stat.periodIsZero = (effPer == '0);
    stat.dirDown      = dirQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ    <= '0;
      perQ    <= '0;
      cmpQ    <= '0;
      shadowQ <= '0;
      dirQ    <= 1'b0;
    end else begin
      if (cmpWrEn) shadowQ <= cmpWrData;
      if (strobe.loadActive) begin
        perQ <= periodIn;
        cmpQ <= shadowQ;
      end
      if (strobe.zeroCnt)       cntQ <= '0;
      else if (strobe.stepUp)   cntQ <= cntInc;
      else if (strobe.stepDown) cntQ <= cntQ - ONE;
      if (strobe.zeroCnt || strobe.turnUp) dirQ <= 1'b0;
      else if (strobe.turnDown)            dirQ <= 1'b1;
    end
  end

  assign cntOut  = cntQ;
  assign dirDown = dirQ;

  // R3: active compare only moves after a cycle at counter zero
  a_r3_load_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cmpQ) |-> $past(cntQ) == '0);

  // R1: descending never coincides with counter zero
  a_r1_down_not_zero: assert property (@(posedge clk) disable iff (!rstN)
    dirQ |-> cntQ != '0);

endmodule

// File: rtl/pwm_updown_ctrl.sv
module pwm_updown_ctrl
  import pwm_updown_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       en,
  input  logic       irqDownSel,
  input  logic [1:0] actUp,
  input  logic [1:0] actDown,
  input  logic       irqClr,
  input  statT       stat,
  output strobeT     strobe,
  output logic       pwmOut,
  output logic       irqPulse,
  output logic       irqFlag
);

  logic matchNow;
  logic actUpHit;
  logic actDownHit;
  logic irqUpHit;
  logic irqDownHit;
  logic irqEvent;
  logic pwmQ;
  logic pulseQ;
  logic flagQ;

  // counter sequencing
  always_comb begin
    strobe.zeroCnt    = !en;
    strobe.stepUp     = en && !stat.dirDown && !stat.periodIsZero;
    strobe.turnDown   = strobe.stepUp && stat.upHitsPeriod;
    strobe.stepDown   = en && stat.dirDown;
    strobe.turnUp     = strobe.stepDown && stat.downHitsZero;
    strobe.loadActive = stat.cntIsZero;
  end

  // direction tagging: the peak belongs to the ascent for actions,
  // to the descent for interrupts
  assign matchNow   = en && stat.cmpEq;
  assign actUpHit   = matchNow && (!stat.dirDown || stat.cntIsPeriod);
  assign actDownHit = matchNow && stat.dirDown && !stat.cntIsPeriod;
  assign irqUpHit   = matchNow && !stat.dirDown;
  assign irqDownHit = matchNow && stat.dirDown;
  assign irqEvent   = irqDownSel ? irqDownHit : irqUpHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pwmQ   <= 1'b0;
      pulseQ <= 1'b0;
      flagQ  <= 1'b0;
    end else begin
      if (actUpHit)        pwmQ <= applyAct(pwmQ, actUp);
      else if (actDownHit) pwmQ <= applyAct(pwmQ, actDown);
      pulseQ <= irqEvent;
      flagQ  <= irqEvent || (flagQ && !irqClr);
    end
  end

  assign pwmOut   = pwmQ;
  assign irqPulse = pulseQ;
  assign irqFlag  = flagQ;

  // R10: disabled run parks the counter at zero counting up
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> stat.cntIsZero && !stat.dirDown);

  // R9: the flag only drops on a clear
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    flagQ && !irqClr |=> flagQ);

  // R8: every pulse is reflected in the flag
  a_r8_pulse_flag: assert property (@(posedge clk) disable iff (!rstN)
    pulseQ |-> flagQ);

  // R10: no output change while disabled
  a_r10_pwm_hold: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> $stable(pwmQ));

endmodule

// File: rtl/pwm_updown_gen.sv
module pwm_updown_gen
  import pwm_updown_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             en,
  input  logic [CNT_W-1:0] periodIn,
  input  logic             cmpWrEn,
  input  logic [CNT_W-1:0] cmpWrData,
  input  logic             irqDownSel,
  input  logic [1:0]       actUp,
  input  logic [1:0]       actDown,
  input  logic             irqClr,
  output logic             pwmOut,
  output logic [CNT_W-1:0] cntOut,
  output logic             dirDown,
  output logic             irqPulse,
  output logic             irqFlag
);

  strobeT strobe;
  statT   stat;

  pwm_updown_dp #(.CNT_W(CNT_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .periodIn  (periodIn),
    .cmpWrEn   (cmpWrEn),
    .cmpWrData (cmpWrData),
    .strobe    (strobe),
    .stat      (stat),
    .cntOut    (cntOut),
    .dirDown   (dirDown)
  );

  pwm_updown_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .en         (en),
    .irqDownSel (irqDownSel),
    .actUp      (actUp),
    .actDown    (actDown),
    .irqClr     (irqClr),
    .stat       (stat),
    .strobe     (strobe),
    .pwmOut     (pwmOut),
    .irqPulse   (irqPulse),
    .irqFlag    (irqFlag)
  );

endmodule

// File: tb/tb_pwm_updown_gen.sv
module tb_pwm_updown_gen;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         en = 1'b0;
  logic [W-1:0] periodIn = '0;
  logic         cmpWrEn = 1'b0;
  logic [W-1:0] cmpWrData = '0;
  logic         irqDownSel = 1'b0;
  logic [1:0]   actUp = 2'd0;
  logic [1:0]   actDown = 2'd0;
  logic         irqClr = 1'b0;
  logic         pwmOut;
  logic [W-1:0] cntOut;
  logic         dirDown;
  logic         irqPulse;
  logic         irqFlag;

  pwm_updown_gen #(.CNT_W(W)) dut (
    .clk(clk), .rstN(rstN), .en(en), .periodIn(periodIn),
    .cmpWrEn(cmpWrEn), .cmpWrData(cmpWrData), .irqDownSel(irqDownSel),
    .actUp(actUp), .actDown(actDown), .irqClr(irqClr),
    .pwmOut(pwmOut), .cntOut(cntOut), .dirDown(dirDown),
    .irqPulse(irqPulse), .irqFlag(irqFlag)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model state
  int   mCnt = 0, mPer = 0, mCmp = 0, mSh = 0;
  bit   mDn = 0, mPwm = 0, mPulse = 0, mFlag = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  function automatic bit actOn(input bit cur, input logic [1:0] code);
    case (code)
      2'd1: return 1'b1;
      2'd2: return 1'b0;
      2'd3: return ~cur;
      default: return cur;
    endcase
  endfunction

  task automatic modelEdge();
    bit eq, upA, dnA, evt;
    eq  = en && (mCnt == mCmp);
    upA = eq && (!mDn || mCnt == mPer);
    dnA = eq && mDn && (mCnt != mPer);
    evt = eq && (irqDownSel ? mDn : !mDn);
    if (upA) mPwm = actOn(mPwm, actUp);
    else if (dnA) mPwm = actOn(mPwm, actDown);
    mFlag  = evt || (mFlag && !irqClr);
    mPulse = evt;
    if (mCnt == 0) begin
      mPer = int'(periodIn);
      mCmp = mSh;
    end
    if (cmpWrEn) mSh = int'(cmpWrData);
    if (!en) begin
      mCnt = 0; mDn = 0;
    end else if (!mDn) begin
      if (mPer != 0) begin
        mCnt++;
        if (mCnt == mPer) mDn = 1;
      end
    end else begin
      mCnt--;
      if (mCnt == 0) mDn = 0;
    end
  endtask

  // one clock: model follows the edge, outputs compared at the falling edge
  task automatic stepCycle();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    chk(int'(cntOut) == mCnt && dirDown == mDn, "R1 counter/direction",
        {cntOut, 7'b0, dirDown}, {mCnt[15:0], 7'b0, mDn});
    chk(pwmOut == mPwm, "R7 pwm level", pwmOut, mPwm);
    chk(irqPulse == mPulse, "R8 irq pulse", irqPulse, mPulse);
    chk(irqFlag == mFlag, "R9 irq flag", irqFlag, mFlag);
  endtask

  task automatic stepN(input int n, output int pulses, output int toggles);
    pulses = 0; toggles = 0;
    for (int i = 0; i < n; i++) begin
      bit prev;
      prev = pwmOut;
      stepCycle();
      if (irqPulse) pulses++;
      if (pwmOut != prev) toggles++;
    end
  endtask

  task automatic writeCmp(input int v);
    cmpWrEn = 1'b1; cmpWrData = W'(v);
    stepCycle();
    cmpWrEn = 1'b0;
  endtask

  task automatic waitFor(input int c, input bit d);
    int k = 0;
    while (!(int'(cntOut) == c && dirDown == d) && k < 300) begin
      stepCycle(); k++;
    end
  endtask

  task automatic runToZero(output int mx);
    int k = 0;
    mx = 0;
    do begin
      stepCycle(); k++;
      if (int'(cntOut) > mx) mx = int'(cntOut);
    end while (cntOut != '0 && k < 300);
  endtask

  task automatic scen(input int per, input int c, input bit sel, input logic [1:0] aU,
                      input logic [1:0] aD, input int expP, input int expT, input string tag);
    int p, t;
    en = 1'b1; periodIn = W'(per); irqDownSel = sel; actUp = aU; actDown = aD;
    writeCmp(c);
    stepN(40, p, t);
    stepN(2 * per, p, t);
    chk(p == expP, {tag, " pulses per cycle"}, p, expP);
    chk(t == expT, {tag, " toggles per cycle"}, t, expT);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int p, t, mx;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // reset state
    chk(cntOut == '0 && !dirDown, "R1 reset counter", cntOut, 0);
    chk(!pwmOut && !irqPulse && !irqFlag, "R7 reset outputs", {pwmOut, irqPulse, irqFlag}, 0);
    rstN = 1'b1;

    // R10: disabled, no events even with a zero compare
    en = 1'b0; periodIn = W'(8);
    stepN(20, p, t);
    chk(p == 0 && t == 0 && cntOut == '0, "R10 idle no events", p + t, 0);

    // R4 interior compare, both directions
    scen(8, 3, 1'b0, 2'd3, 2'd3, 1, 2, "R4 up sel");
    scen(8, 3, 1'b1, 2'd3, 2'd3, 1, 2, "R4 down sel");
    // R5 compare at zero
    scen(8, 0, 1'b0, 2'd3, 2'd0, 1, 1, "R5 up sel");
    scen(8, 0, 1'b1, 2'd3, 2'd3, 0, 1, "R5 down sel");
    // R6 compare at period
    scen(8, 8, 1'b0, 2'd3, 2'd3, 0, 1, "R6 up sel");
    scen(8, 8, 1'b1, 2'd0, 2'd3, 1, 0, "R6 down sel");
    // R11 compare beyond period
    scen(8, 9, 1'b1, 2'd3, 2'd3, 0, 0, "R11 beyond");

    // R3: mid-cycle shadow write not used until zero
    irqDownSel = 1'b0;
    waitFor(2, 1'b0);
    writeCmp(3);
    runToZero(mx);
    stepN(0, p, t);
    chk(mx == 8, "R3 run reached period", mx, 8);
    begin
      int q;
      q = 0;
      // pulses seen during the rest of this cycle were counted as none
      stepN(2 * 8, q, t);
      chk(q == 1, "R3 new compare active after zero", q, 1);
    end

    // R9: clear coinciding with an event keeps the flag
    waitFor(3, 1'b0);
    irqClr = 1'b1;
    stepCycle();
    chk(irqFlag == 1'b1, "R9 clear with event", irqFlag, 1);
    stepCycle();
    chk(irqFlag == 1'b0, "R9 clear alone", irqFlag, 0);
    irqClr = 1'b0;

    // R2: period change takes effect at next zero
    waitFor(4, 1'b0);
    periodIn = W'(5);
    runToZero(mx);
    chk(mx == 8, "R2 old period kept", mx, 8);
    runToZero(mx);
    chk(mx == 5, "R2 new period used", mx, 5);
    periodIn = '0;
    waitFor(0, 1'b0);
    stepCycle();
    stepN(6, p, t);
    chk(cntOut == '0 && !dirDown, "R2 zero period holds", cntOut, 0);

    // random phase
    periodIn = W'(6);
    for (int i = 0; i < 4000; i++) begin
      en = ($urandom % 16) != 0;
      if ($urandom % 50 == 0) periodIn = W'($urandom % 13);
      cmpWrEn = ($urandom % 10 == 0);
      cmpWrData = W'($urandom % 14);
      if ($urandom % 40 == 0) irqDownSel = ~irqDownSel;
      if ($urandom % 40 == 0) actUp = 2'($urandom);
      if ($urandom % 40 == 0) actDown = 2'($urandom);
      irqClr = ($urandom % 8 == 0);
      stepCycle();
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule